// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is an eight-pin general-purpose I/O port that sits on the register bus of a small microcontroller core. Two writable registers control the port: an output data latch and a direction register. A third, read-only address returns the live logic levels on the pads after they pass through a two-flop synchroniser. For each pin the block drives three pad controls: an output enable, an output value and a weak pull-up enable. The pad cell itself and its analogue behaviour lie outside the block.

A pin whose direction bit is one is an output, and it is driven push-pull from its latch bit. A pin whose direction bit is zero is an input. On an input pin the latch bit turns the weak pull-up on or off. Each pin also has an alternate-function hook: while the hook's enable is high, its value replaces the latch bit on the pad, and the latch keeps its contents. The compare-match output of a timer on pin 5 is the typical user of this hook. An alternate output reaches the pad only when that pin is set as an output.

Reset is active-low. Asserting it clears both registers at once, with or without a running clock, so every pad stops driving and every pull-up turns off. The release of reset is synchronised to the clock.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst_n` is low, `pad_oe` and `pad_pu` are all zero and the data and direction registers read as zero. This holds even when no clock edge occurs after `rst_n` falls.
- R2: `pad_oe[i]` equals bit i of the direction register, so a one makes pin i an output.
- R3: `pad_pu[i]` is one only when direction bit i is zero and latch bit i is one.
- R4: On an output pin with its alternate enable low, `pad_out[i]` equals latch bit i.
- R5: A read with `bus_addr` = 0x12 returns the latch, and a read with `bus_addr` = 0x11 returns the direction register. Reads are combinational.
- R6: A read with `bus_addr` = 0x10 returns the pad levels as they were sampled two rising clock edges earlier.
- R7: A write to address 0x10 changes neither register.
- R8: While `alt_en[i]` is high, `pad_out[i]` equals `alt_val[i]` and the latch keeps its contents. The alternate value drives the pad only when direction bit i is one.
- R9: A write with `bus_wr` high is visible on the pad controls and in reads from the first rising edge after it is presented.
- R10: A read from any address other than 0x10, 0x11 or 0x12 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | I/O address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 8 | Logic level seen at each pad |
| pad_oe | output | 8 | Output driver enable per pad |
| pad_out | output | 8 | Output value per pad |
| pad_pu | output | 8 | Weak pull-up enable per pad |
| alt_en | input | 8 | Alternate-function override enable per pin |
| alt_val | input | 8 | Alternate-function output value per pin |

## Verification
The bench stops the clock and then pulls reset low. A design whose reset only acts on a clock edge would leave the pads driving, and this test catches it. The bench writes to the pin-input address while the latch and direction register hold non-zero values. A decoder that lets that write through would corrupt one of the registers. It enables the alternate function on pin 5 both as an output and as an input, and it reads the latch back afterwards. This exposes a design that lets the alternate function drive an input pin, or one that writes the alternate value into the latch. The pad model changes the external levels while the bench reads pin values. A synchroniser with the wrong number of stages then returns its data one cycle early or late.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PIN  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_out_n = shift_q[STAGES-1];

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data_en,
  input  logic         wr_dir_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q
);

  logic [W-1:0] latch_d;
  logic [W-1:0] dir_d;

  always_comb begin
    latch_d = latch_q;
    dir_d   = dir_q;
    if (wr_data_en) latch_d = wdata;
    if (wr_dir_en)  dir_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_in[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign sync_out[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int W = 8
) (
  input  logic [W-1:0] latch,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] alt_en,
  input  logic [W-1:0] alt_val,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);

  for (genvar b = 0; b < W; b++) begin : g_pin
    always_comb begin
      pad_oe[b]  = dir[b];
      pad_out[b] = alt_en[b] ? alt_val[b] : latch[b];
      pad_pu[b]  = ~dir[b] & latch[b];
    end
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int              W         = 8,
  parameter int              ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] ADDR_PIN  = 6'h10,
  parameter logic [ADDR_W-1:0] ADDR_DIR  = 6'h11,
  parameter logic [ADDR_W-1:0] ADDR_DATA = 6'h12,
  parameter int              SYNC_STAGES = 2,
  parameter int              RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_pu,
  input  logic [W-1:0]      alt_en,
  input  logic [W-1:0]      alt_val
);
  import gpio_pkg::*;

  logic         rst_int_n;
  reg_sel_e     sel;
  logic         wr_data_en;
  logic         wr_dir_en;
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] pin_sync;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_out_n (rst_int_n)
  );

  always_comb begin
    if      (bus_addr == ADDR_DATA) sel = SEL_DATA;
    else if (bus_addr == ADDR_DIR)  sel = SEL_DIR;
    else if (bus_addr == ADDR_PIN)  sel = SEL_PIN;
    else                            sel = SEL_NONE;
  end

  always_comb begin
    wr_data_en = bus_wr && (sel == SEL_DATA);
    wr_dir_en  = bus_wr && (sel == SEL_DIR);
  end

  gpio_ctrl_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_data_en (wr_data_en),
    .wr_dir_en  (wr_dir_en),
    .wdata      (bus_wdata),
    .latch_q    (latch_q),
    .dir_q      (dir_q)
  );

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_pad_mux #(.W(W)) u_pad_mux (
    .latch   (latch_q),
    .dir     (dir_q),
    .alt_en  (alt_en),
    .alt_val (alt_val),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .pad_pu  (pad_pu)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: bus_rdata = latch_q;
      SEL_DIR:  bus_rdata = dir_q;
      SEL_PIN:  bus_rdata = pin_sync;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int                W         = 8,
  parameter int                ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] ADDR_PIN  = 6'h10,
  parameter logic [ADDR_W-1:0] ADDR_DIR  = 6'h11,
  parameter logic [ADDR_W-1:0] ADDR_DATA = 6'h12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      pad_in,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_pu,
  input logic [W-1:0]      alt_en,
  input logic [W-1:0]      alt_val
);

  logic [3:0] live_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             live_cnt <= '0;
    else if (live_cnt != 4'hF) live_cnt <= live_cnt + 4'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_pu == '0));

  // R9
  dir_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 4'd3 && bus_wr && bus_addr == ADDR_DIR) |=> pad_oe == $past(bus_wdata));

  // R7
  pin_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 4'd3 && bus_wr && bus_addr == ADDR_PIN) |=> ($stable(pad_oe) && $stable(pad_pu)));

  // R3
  pull_only_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  // R8
  alt_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_en & pad_oe & (pad_out ^ alt_val)) == '0);

  // R6
  pin_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 4'd6 && bus_addr == ADDR_PIN) |-> bus_rdata == $past(pad_in, 2));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_PIN && bus_addr != ADDR_DIR && bus_addr != ADDR_DATA) |-> bus_rdata == '0);

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
  .W(W), .ADDR_W(ADDR_W), .ADDR_PIN(ADDR_PIN), .ADDR_DIR(ADDR_DIR), .ADDR_DATA(ADDR_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
  .pad_pu(pad_pu), .alt_en(alt_en), .alt_val(alt_val)
);

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;

  localparam int CLK_HALF = 5;

  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = 6'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in;
  logic [7:0] pad_oe, pad_out, pad_pu;
  logic [7:0] alt_en = 8'h00, alt_val = 8'h00;
  logic [7:0] ext_en = 8'h00, ext_val = 8'h00;

  int checks = 0;
  int errors = 0;

  always #CLK_HALF if (clk_run) clk = ~clk;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .alt_en(alt_en), .alt_val(alt_val)
  );

  // Pad resolver: own driver, else external driver, else pull-up, else floats low.
  always_comb begin
    for (int i = 0; i < 8; i++) begin
      if (pad_oe[i])      pad_in[i] = pad_out[i];
      else if (ext_en[i]) pad_in[i] = ext_val[i];
      else                pad_in[i] = pad_pu[i];
    end
  end

  // Behavioural reference model
  logic [7:0] m_data = 8'h00, m_dir = 8'h00;
  logic [7:0] m_hist[$];
  int         m_rel = 0;

  initial begin
    m_hist.push_front(8'h00);
    m_hist.push_front(8'h00);
  end

  always @(negedge rst_n) begin
    m_data = 8'h00; m_dir = 8'h00; m_rel = 0;
    m_hist.delete();
    m_hist.push_front(8'h00);
    m_hist.push_front(8'h00);
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (m_rel >= 2) begin
        if (bus_wr && bus_addr == 6'h12) m_data = bus_wdata;
        if (bus_wr && bus_addr == 6'h11) m_dir  = bus_wdata;
        m_hist.push_front(pad_in);
        void'(m_hist.pop_back());
      end
      m_rel++;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] exp_rd;
    logic [7:0] exp_out;
    check("R2 pad_oe", pad_oe, m_dir);
    check("R3 pad_pu", pad_pu, ~m_dir & m_data);
    for (int i = 0; i < 8; i++) exp_out[i] = alt_en[i] ? alt_val[i] : m_data[i];
    check("R4/R8 pad_out on outputs", pad_out & m_dir, exp_out & m_dir);
    case (bus_addr)
      6'h12:   exp_rd = m_data;
      6'h11:   exp_rd = m_dir;
      6'h10:   exp_rd = m_hist[1];
      default: exp_rd = 8'h00;
    endcase
    check("R5/R6/R10 bus_rdata", bus_rdata, exp_rd);
  endtask

  task automatic step(input logic [5:0] a, input logic w, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d;
    @(posedge clk);
    #2;
    compare_all();
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #2;
    check("R1 oe in reset", pad_oe, 8'h00);
    check("R1 pu in reset", pad_pu, 8'h00);
    bus_addr = 6'h12; #1;
    check("R1 data reads zero", bus_rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(6'h12, 1'b0, 8'h00);

    // R9 write timing and R5 readback
    step(6'h11, 1'b1, 8'hF0);
    check("R9 dir visible next edge", pad_oe, 8'hF0);
    step(6'h12, 1'b1, 8'hA5);
    check("R9 data visible next edge", bus_rdata, 8'hA5);
    check("R3 pull-ups on low inputs", pad_pu, 8'h05);
    step(6'h11, 1'b0, 8'h00);
    check("R5 dir readback", bus_rdata, 8'hF0);

    // R6 pin reads with external drive on inputs
    ext_en = 8'h0F; ext_val = 8'h0A;
    repeat (3) step(6'h10, 1'b0, 8'h00);
    check("R6 pin levels", bus_rdata, 8'hAA);
    ext_val = 8'h05;
    step(6'h10, 1'b0, 8'h00);
    check("R6 lag before update", bus_rdata, 8'hAA);
    step(6'h10, 1'b0, 8'h00);
    check("R6 after two edges", bus_rdata, 8'hA5);

    // R7 pin address write ignored
    step(6'h10, 1'b1, 8'h3C);
    step(6'h12, 1'b0, 8'h00);
    check("R7 latch kept", bus_rdata, 8'hA5);
    step(6'h11, 1'b0, 8'h00);
    check("R7 dir kept", bus_rdata, 8'hF0);

    // R8 alternate function on pin 5
    alt_en = 8'h20; alt_val = 8'h00;
    step(6'h12, 1'b0, 8'h00);
    check("R8 alt overrides output", pad_out & 8'h20, 8'h00);
    check("R8 latch kept", bus_rdata, 8'hA5);
    step(6'h11, 1'b1, 8'hD0);
    check("R8 alt not driven on input", pad_oe & 8'h20, 8'h00);
    alt_en = 8'h00;

    // R10 unmapped
    step(6'h13, 1'b1, 8'hFF);
    check("R10 unmapped reads zero", bus_rdata, 8'h00);
    step(6'h12, 1'b0, 8'h00);
    check("R10 unmapped write ignored", bus_rdata, 8'hA5);

    // Mixed patterns, model compared every clock
    for (int k = 0; k < 60; k++) begin
      logic [7:0] v;
      v = 8'((k * 37 + 11) ^ (k << 3));
      ext_en  = ~m_dir;
      ext_val = v ^ 8'h5A;
      alt_en  = (k % 5 == 0) ? 8'h20 : 8'h00;
      alt_val = v;
      case (k % 4)
        0: step(6'h12, 1'b1, v);
        1: step(6'h11, 1'b1, v ^ 8'hC3);
        2: step(6'h10, (k % 8) == 2, v);
        default: step(6'(k), 1'b0, 8'h00);
      endcase
    end
    alt_en = 8'h00; ext_en = 8'h00;

    // R1 asynchronous reset with clock stopped
    step(6'h11, 1'b1, 8'hFF);
    step(6'h12, 1'b1, 8'h0F);
    @(negedge clk);
    bus_wr = 1'b0;
    clk_run = 1'b0;
    #20;
    rst_n = 1'b0;
    #3;
    check("R1 oe cleared without clock", pad_oe, 8'h00);
    check("R1 pu cleared without clock", pad_pu, 8'h00);
    bus_addr = 6'h12; #1;
    check("R1 latch cleared without clock", bus_rdata, 8'h00);
    clk_run = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step(6'h11, 1'b0, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule